// File: doc/BRIEF.md
# ATA Cycle Timing Encoder

This block turns a requested drive transfer timing, given in nanoseconds, into the two packed timing bytes a disk-channel controller uses for one drive: an active/recovery byte and an address-setup byte. The caller supplies three times: the full cycle, the strobe-active portion and the address setup. It also gives the bus clock period in nanoseconds, selects a channel and a drive, and pulses start. The block rounds each time up to whole clock periods, shapes the counts to fit the limited fields, encodes them, and pulses done once both bytes are ready.

The rounding is a ceiling division, carried out one after another on a single restoring divider. The excess of an over-long recovery phase is moved into the active phase. Both counts use non-linear codes, and a count of 16 is encoded as zero. The secondary channel has only one setup field, which its two drives share. For that channel the block keeps the last setup count of each drive and encodes the larger of the two. Fixed multiword-DMA timings (mode 0: 480/215 ns, mode 1: 150/80 ns, mode 2: 120/70 ns) are applied by presenting those cycle/active pairs on the time inputs.

Top module: `ata_timing_enc`

## Requirements
- R1: Every count is the ceiling of the time over the clock period, (time + period - 1) / period, so 90 ns at 30 ns gives 3 and 91 ns gives 4.
- R2: The recovery count is the cycle count minus the active count, and it is 0 when the cycle count does not exceed the active count.
- R3: When the recovery count exceeds 16, the amount above 16 is added to the active count and recovery becomes 16.
- R4: After that step the active count is limited to 16. The active/recovery byte carries the low 4 bits of the active count in bits 7:4 (so 16 gives 0) and the recovery code in bits 3:0.
- R5: The recovery code is 15 for counts 0 and 1, n-1 for counts 2 to 15, and 0 for a count of 16.
- R6: The setup count is limited to 5 and encoded in bits 7:6 of the setup byte: counts 0 to 2 give 2'b01, 3 gives 2'b10, 4 gives 2'b00 and 5 gives 2'b11. Bits 5:0 are zero.
- R7: On the secondary channel (channel select 1), the new setup count is stored for the selected drive (drive select 0 or 1). The larger of it and the count stored for the other drive is encoded.
- R8: On the primary channel (channel select 0), the drive's own setup count is encoded and the stored counts are left unchanged.
- R9: Reset clears both stored setup counts and both output bytes to 0, and holds done low.
- R10: Done is high for exactly one cycle per accepted start. The output bytes change only in that cycle and then hold.
- R11: A start while an operation is in progress is ignored. The inputs are captured when the start is accepted, so later changes on them do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an encoding when idle |
| cycle_ns_i | input | TIME_W | Total cycle time in ns |
| active_ns_i | input | TIME_W | Active (strobe) time in ns |
| setup_ns_i | input | TIME_W | Address setup time in ns |
| period_ns_i | input | PER_W | Bus clock period in ns, at least 1 |
| channel_i | input | 1 | 0 primary, 1 secondary |
| drive_i | input | 1 | Drive on the channel |
| drw_byte_o | output | 8 | Active code [7:4], recovery code [3:0] |
| setup_byte_o | output | 8 | Setup code [7:6], zero below |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its defaults, TIME_W = 11 and PER_W = 8. With these, times near 2000 ns combine with a 15 ns period to give cycle counts above 130, which drives the excess-recovery path and both caps well past their limits. The same widths also allow exact-multiple and one-over cases at small periods. Shared-field merging on the secondary channel is checked through sequences that alternate drives and channels, with a reset placed between two of them.

// File: rtl/ata_timing_pkg.sv
// Package: shared state type, limits and field encodings for the
// cycle timing encoder. Assumes counts arrive already limited.
package ata_timing_pkg;

    localparam int CNT_LIMIT   = 16;
    localparam int SETUP_LIMIT = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CYC,
        ST_ACT,
        ST_SET,
        ST_OUT
    } enc_state_t;

    // Recovery count (0..16) to 4-bit field code.
    function automatic logic [3:0] rec_encode(input logic [4:0] n);
        logic [3:0] code;
        if (n <= 5'd1)
            code = 4'd15;
        else if (n >= 5'd16)
            code = 4'd0;
        else
            code = 4'(n - 5'd1);
        return code;
    endfunction

    // Setup count (0..5) to 2-bit field code.
    function automatic logic [1:0] setup_encode(input logic [2:0] n);
        logic [1:0] code;
        case (n)
            3'd3:    code = 2'b10;
            3'd4:    code = 2'b00;
            3'd5:    code = 2'b11;
            default: code = 2'b01;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/ata_ceil_div.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
// Assumes den is nonzero; a start is only issued while not busy.
// done pulses one cycle after the last bit, with quo valid and held.
module ata_ceil_div #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] q_r;
    logic [DEN_W:0]   r_r;
    logic [DEN_W-1:0] d_r;
    logic [CNT_W-1:0] cnt_r;
    logic             busy_r;
    logic             done_r;
    logic [DEN_W:0]   shifted;
    logic [DEN_W+1:0] diff;
    logic             ge;

    // Trial subtraction of the divisor from the shifted remainder.
    always_comb begin
        shifted = {r_r[DEN_W-1:0], q_r[NUM_W-1]};
        diff    = {1'b0, shifted} - {2'b00, d_r};
        ge      = ~diff[DEN_W+1];
    end

    // Iteration registers: load on start, one bit per cycle after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= '0;
            r_r    <= '0;
            d_r    <= '0;
            cnt_r  <= '0;
            busy_r <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (start && !busy_r) begin
                q_r    <= num;
                r_r    <= '0;
                d_r    <= den;
                cnt_r  <= CNT_W'(NUM_W);
                busy_r <= 1'b1;
            end else if (busy_r) begin
                q_r   <= {q_r[NUM_W-2:0], ge};
                r_r   <= ge ? diff[DEN_W:0] : shifted;
                cnt_r <= cnt_r - CNT_W'(1);
                if (cnt_r == CNT_W'(1)) begin
                    busy_r <= 1'b0;
                    done_r <= 1'b1;
                end
            end
        end
    end

    assign done = done_r;
    assign quo  = q_r;
endmodule

// File: rtl/ata_count_shaper.sv
// Combinational shaping of cycle/active counts into the active/recovery
// byte: saturating subtraction, excess recovery folded into active,
// caps at 16, then field encoding. Assumes counts fit QW bits.
module ata_count_shaper
    import ata_timing_pkg::*;
#(
    parameter int QW = 12
) (
    input  logic [QW-1:0] cyc_cnt,
    input  logic [QW-1:0] act_cnt,
    output logic [4:0]    act_lim,
    output logic [4:0]    rec_lim,
    output logic [7:0]    drw_byte
);
    localparam logic [QW-1:0] LIM = QW'(CNT_LIMIT);

    logic [QW-1:0] rec_w;
    logic [QW-1:0] act_w;

    // Recovery from the count difference, excess moved to active.
    always_comb begin
        rec_w = (cyc_cnt > act_cnt) ? (cyc_cnt - act_cnt) : '0;
        act_w = act_cnt;
        if (rec_w > LIM) begin
            act_w = act_cnt + (rec_w - LIM);
            rec_w = LIM;
        end
        if (act_w > LIM)
            act_w = LIM;
        act_lim  = act_w[4:0];
        rec_lim  = rec_w[4:0];
        drw_byte = {act_lim[3:0], rec_encode(rec_lim)};
    end
endmodule

// File: rtl/ata_setup_merge.sv
// Per-drive setup count store for the shared-field channel and the
// merge that picks the larger of the two drives. Primary-channel
// requests pass straight through and leave the store untouched.
module ata_setup_merge #(
    parameter int NUM_DRV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       chan_i,
    input  logic       drive_i,
    input  logic [2:0] cnt_i,
    output logic [2:0] merged_o
);
    logic [2:0] slot_q [NUM_DRV];
    logic [2:0] other;

    for (genvar g = 0; g < NUM_DRV; g++) begin : g_slot
        // Store the new count for the addressed secondary drive.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= 3'd0;
            else if (wr_en && chan_i && (drive_i == 1'(g)))
                slot_q[g] <= cnt_i;
        end
    end

    // Larger of this drive and its neighbour on the secondary channel.
    always_comb begin
        other    = slot_q[drive_i ^ 1'b1];
        merged_o = cnt_i;
        if (chan_i && (other > cnt_i))
            merged_o = other;
    end
endmodule

// File: rtl/ata_timing_enc.sv
// Top: accepts a timing request when idle, runs three ceiling divisions
// (cycle, active, setup) on one divider, shapes and encodes the counts,
// and registers both bytes with a one-cycle done strobe.
// Assumes period_ns_i >= 1 and that time + period - 1 fits TIME_W+1 bits.
module ata_timing_enc
    import ata_timing_pkg::*;
#(
    parameter int TIME_W = 11,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TIME_W-1:0] cycle_ns_i,
    input  logic [TIME_W-1:0] active_ns_i,
    input  logic [TIME_W-1:0] setup_ns_i,
    input  logic [PER_W-1:0]  period_ns_i,
    input  logic              channel_i,
    input  logic              drive_i,
    output logic [7:0]        drw_byte_o,
    output logic [7:0]        setup_byte_o,
    output logic              done_o
);
    localparam int QW = TIME_W + 1;

    enc_state_t        st_q;
    logic [TIME_W-1:0] act_ns_q;
    logic [TIME_W-1:0] set_ns_q;
    logic [PER_W-1:0]  per_q;
    logic              ch_q;
    logic              drv_q;
    logic [QW-1:0]     cyc_cnt_q;
    logic [QW-1:0]     act_cnt_q;
    logic [QW-1:0]     set_cnt_q;

    logic [TIME_W-1:0] t_sel;
    logic [PER_W-1:0]  d_sel;
    logic [QW-1:0]     div_num;
    logic              div_start;
    logic              div_done;
    logic [QW-1:0]     div_quo;

    logic [4:0]        act_cnt;
    logic [4:0]        rec_cnt;
    logic [7:0]        drw_next;
    logic [2:0]        set_lim;
    logic [2:0]        merged_cnt;
    logic              store_wr;

    // Operand select for the next division and its ceiling numerator.
    always_comb begin
        case (st_q)
            ST_IDLE: begin t_sel = cycle_ns_i; d_sel = period_ns_i; end
            ST_CYC:  begin t_sel = act_ns_q;   d_sel = per_q;       end
            default: begin t_sel = set_ns_q;   d_sel = per_q;       end
        endcase
        div_num   = QW'(t_sel) + QW'(d_sel) - QW'(1);
        div_start = ((st_q == ST_IDLE) && start_i) ||
                    (((st_q == ST_CYC) || (st_q == ST_ACT)) && div_done);
    end

    ata_ceil_div #(
        .NUM_W (QW),
        .DEN_W (PER_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (d_sel),
        .done  (div_done),
        .quo   (div_quo)
    );

    ata_count_shaper #(
        .QW (QW)
    ) u_shape (
        .cyc_cnt  (cyc_cnt_q),
        .act_cnt  (act_cnt_q),
        .act_lim  (act_cnt),
        .rec_lim  (rec_cnt),
        .drw_byte (drw_next)
    );

    // Setup count limited to the field range before merging.
    always_comb begin
        set_lim  = (set_cnt_q > QW'(SETUP_LIMIT)) ? 3'(SETUP_LIMIT)
                                                   : set_cnt_q[2:0];
        store_wr = (st_q == ST_OUT);
    end

    ata_setup_merge #(
        .NUM_DRV (2)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (store_wr),
        .chan_i   (ch_q),
        .drive_i  (drv_q),
        .cnt_i    (set_lim),
        .merged_o (merged_cnt)
    );

    // Sequencer: capture request, collect three quotients, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            act_ns_q     <= '0;
            set_ns_q     <= '0;
            per_q        <= '0;
            ch_q         <= 1'b0;
            drv_q        <= 1'b0;
            cyc_cnt_q    <= '0;
            act_cnt_q    <= '0;
            set_cnt_q    <= '0;
            drw_byte_o   <= 8'h00;
            setup_byte_o <= 8'h00;
            done_o       <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (st_q)
                ST_IDLE: if (start_i) begin
                    act_ns_q <= active_ns_i;
                    set_ns_q <= setup_ns_i;
                    per_q    <= period_ns_i;
                    ch_q     <= channel_i;
                    drv_q    <= drive_i;
                    st_q     <= ST_CYC;
                end
                ST_CYC: if (div_done) begin
                    cyc_cnt_q <= div_quo;
                    st_q      <= ST_ACT;
                end
                ST_ACT: if (div_done) begin
                    act_cnt_q <= div_quo;
                    st_q      <= ST_SET;
                end
                ST_SET: if (div_done) begin
                    set_cnt_q <= div_quo;
                    st_q      <= ST_OUT;
                end
                default: begin
                    drw_byte_o   <= drw_next;
                    setup_byte_o <= {setup_encode(merged_cnt), 6'b000000};
                    done_o       <= 1'b1;
                    st_q         <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ata_timing_enc_chk.sv
// Checker for the cycle timing encoder, bound to every instance of the
// top. Watches the output strobe, the sequencer state and the shaped counts.
module ata_timing_enc_chk
    import ata_timing_pkg::*;
#(
    parameter int QW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done_o,
    input logic [7:0]    drw_byte_o,
    input logic [7:0]    setup_byte_o,
    input enc_state_t    st_q,
    input logic [QW-1:0] cyc_cnt_q,
    input logic [QW-1:0] act_cnt_q,
    input logic [4:0]    act_cnt,
    input logic [4:0]    rec_cnt,
    input logic [2:0]    merged_cnt
);
    // R10: the result strobe lasts a single cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: output bytes move only together with done.
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((drw_byte_o != $past(drw_byte_o)) ||
         (setup_byte_o != $past(setup_byte_o))) |-> done_o);

    // R11: done follows a busy sequencer, never an idle one.
    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(st_q) != ST_IDLE));

    // R2: no recovery when the cycle does not outlast the active phase.
    p_rec_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt_q <= act_cnt_q) |-> (rec_cnt == 5'd0));

    // R4: shaped active count never passes the limit.
    p_act_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_cnt <= 5'd16);

    // R3: recovery never passes the limit.
    p_rec_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_cnt <= 5'd16);

    // R6: merged setup count stays in the field range.
    p_setup_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        merged_cnt <= 3'd5);
endmodule

bind ata_timing_enc ata_timing_enc_chk #(.QW(QW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_o       (done_o),
    .drw_byte_o   (drw_byte_o),
    .setup_byte_o (setup_byte_o),
    .st_q         (st_q),
    .cyc_cnt_q    (cyc_cnt_q),
    .act_cnt_q    (act_cnt_q),
    .act_cnt      (act_cnt),
    .rec_cnt      (rec_cnt),
    .merged_cnt   (merged_cnt)
);

// File: tb/tb_ata_timing_enc.sv
// Bench: vector table on the primary channel, then directed tests for
// reset, shared-field merging and starts during a busy operation.
module tb_ata_timing_enc;
    localparam int CLK_PERIOD = 10;
    localparam int TIME_W = 11;
    localparam int PER_W  = 8;
    localparam int NV = 15;

    localparam int V_CYC [NV] = '{600, 383, 240, 180, 120, 480, 150, 120,
                                  900, 100, 600, 2000, 480,   1,  91};
    localparam int V_ACT [NV] = '{165, 125, 100,  80,  70, 215,  80,  70,
                                  100, 300, 600,   10, 215,   1,  60};
    localparam int V_SET [NV] = '{ 70,  50,  30,  30,  25,  20,  20,  20,
                                   10,  60, 120,  200,  70,   1,  61};
    localparam int V_PER [NV] = '{ 30,  30,  30,  30,  30,  30,  30,  30,
                                   30,  30,  30,   15,  20,   1,  30};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [TIME_W-1:0] cycle_ns_i = '0;
    logic [TIME_W-1:0] active_ns_i = '0;
    logic [TIME_W-1:0] setup_ns_i = '0;
    logic [PER_W-1:0]  period_ns_i = 8'd30;
    logic              channel_i = 1'b0;
    logic              drive_i = 1'b0;
    logic [7:0]        drw_byte_o;
    logic [7:0]        setup_byte_o;
    logic              done_o;

    int checks = 0;
    int errors = 0;
    int mstore [2];

    ata_timing_enc #(.TIME_W(TIME_W), .PER_W(PER_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cycle_ns_i   (cycle_ns_i),
        .active_ns_i  (active_ns_i),
        .setup_ns_i   (setup_ns_i),
        .period_ns_i  (period_ns_i),
        .channel_i    (channel_i),
        .drive_i      (drive_i),
        .drw_byte_o   (drw_byte_o),
        .setup_byte_o (setup_byte_o),
        .done_o       (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ceil_cnt(input int t, input int p);
        return (t + p - 1) / p;
    endfunction

    function automatic int exp_drw(input int c, input int a, input int p);
        int cc, ac, rc, rcode;
        cc = ceil_cnt(c, p);
        ac = ceil_cnt(a, p);
        rc = (cc > ac) ? cc - ac : 0;
        if (rc > 16) begin
            ac = ac + rc - 16;
            rc = 16;
        end
        if (ac > 16) ac = 16;
        if (rc <= 1) rcode = 15;
        else if (rc == 16) rcode = 0;
        else rcode = rc - 1;
        return ((ac % 16) * 16) + rcode;
    endfunction

    function automatic int exp_setup(input int n);
        int code;
        if (n <= 2) code = 1;
        else if (n == 3) code = 2;
        else if (n == 4) code = 0;
        else code = 3;
        return code * 64;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        mstore[0] = 0;
        mstore[1] = 0;
        check("R9 reset drw", int'(drw_byte_o), 0);
        check("R9 reset setup", int'(setup_byte_o), 0);
        check("R9 reset done", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_op(input int c, input int a, input int s, input int p,
                          input bit ch, input bit dv, input string req);
        int sc, merged;
        @(negedge clk);
        cycle_ns_i  = TIME_W'(c);
        active_ns_i = TIME_W'(a);
        setup_ns_i  = TIME_W'(s);
        period_ns_i = PER_W'(p);
        channel_i   = ch;
        drive_i     = dv;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        sc = ceil_cnt(s, p);
        if (sc > 5) sc = 5;
        if (ch) begin
            mstore[dv] = sc;
            merged = (mstore[dv] > mstore[!dv]) ? mstore[dv] : mstore[!dv];
        end else begin
            merged = sc;
        end
        check({req, " drw"}, int'(drw_byte_o), exp_drw(c, a, p));
        check({req, " setup"}, int'(setup_byte_o), exp_setup(merged));
        @(negedge clk);
        check("R10 done single cycle", int'(done_o), 0);
    endtask

    initial begin
        int hold_drw, hold_set, extra;
        do_reset();

        // R1 R2 R3 R4 R5 R6: primary-channel vector table.
        for (int i = 0; i < NV; i++)
            run_op(V_CYC[i], V_ACT[i], V_SET[i], V_PER[i], 1'b0, 1'b0,
                   "R1 R2 R3 R4 R5 R6 vector");

        // R7: shared setup field takes the larger drive count.
        run_op(600, 165, 150, 30, 1'b1, 1'b0, "R7 sec d0 five");
        run_op(600, 165,  30, 30, 1'b1, 1'b1, "R7 sec d1 keeps five");
        run_op(600, 165,  30, 30, 1'b1, 1'b0, "R7 sec d0 both one");
        run_op(600, 165, 100, 30, 1'b1, 1'b1, "R7 sec d1 four");
        // R8: primary request must not disturb stored counts.
        run_op(600, 165, 150, 30, 1'b0, 1'b0, "R8 primary five");
        run_op(600, 165,  30, 30, 1'b1, 1'b0, "R8 sec after primary");

        // R9: reset clears stored counts (drive 1 held four).
        do_reset();
        run_op(600, 165,  30, 30, 1'b1, 1'b0, "R9 store cleared");

        // R11: start during busy ignored, inputs captured at start.
        @(negedge clk);
        cycle_ns_i = 11'd600; active_ns_i = 11'd165; setup_ns_i = 11'd90;
        period_ns_i = 8'd30; channel_i = 1'b0; drive_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cycle_ns_i = 11'd2000; active_ns_i = 11'd10; setup_ns_i = 11'd200;
        period_ns_i = 8'd15;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        check("R11 busy start ignored drw", int'(drw_byte_o), exp_drw(600, 165, 30));
        check("R11 busy start ignored setup", int'(setup_byte_o), exp_setup(3));
        hold_drw = int'(drw_byte_o);
        hold_set = int'(setup_byte_o);
        extra = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check("R11 no second done", extra, 0);
        check("R10 drw held", int'(drw_byte_o), hold_drw);
        check("R10 setup held", int'(setup_byte_o), hold_set);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule